// File: doc/BRIEF.md
# LCD Common/Segment Scan Sequencer

This block drives a multiplexed dot-matrix style LCD of 40 segment pins and 8 common pins. It holds a nibble-wide display memory of 80 words, steps through the commons one phase at a time, and gives every pin a small level-select code. An analog bias ladder outside the block turns that code into a voltage. The host sets the duty (all 8 commons or only the first 4), the bias (four or five voltage levels), a 4-bit frame-rate code and the pin-release controls. The clock is the low-frequency oscillator, nominally 32768 Hz.

A complete pass over the active commons makes up one frame. After each frame the sense of every level code flips, so over two frames each pixel sees a waveform with no DC component. Commons 4 to 7 (in the four-common mode only) and segments 16 to 39 (in blocks of four) can be handed over to general I/O. For those pins the block drops the matching output-enable.

Top module: `lcd_scan_seq`

## Requirements
- R1: Each common phase lasts (rate_code+1)*8 clocks with `duty_full`=1, and twice as long with `duty_full`=0, so a frame is 64*(rate_code+1) clocks in both modes. The reset code 7 gives 512 clocks, which is a 64 Hz frame at 32768 Hz.
- R2: With `duty_full`=1 the commons are selected in turn, 0 up to 7, one per phase, and exactly one common is selected at any time.
- R3: With `duty_full`=0 only commons 0 to 3 are scanned. Commons 4 to 7 stay at the unselected level.
- R4: Level codes are 3 bits wide, and T is 3 when `bias_quarter`=0 and 4 when it is 1. In positive polarity:
  - a selected common outputs T;
  - an unselected common outputs 1;
  - a lit segment outputs 0;
  - an unlit segment outputs 2.
- R5: Polarity starts positive and toggles each time the scan wraps back to common 0. In negative polarity every code listed in R4 becomes T minus that code.
- R6: While common c is active, the pixel of segment s is bit (c mod 4) of display word 2*s + (c >= 4 ? 1 : 0). A bit value of 1 means the segment is lit.
- R7: A write (`wr_en`=1, `wr_addr` below 80) stores `wr_data` at the clock edge. The new pixels appear on the segment outputs in the cycle that follows.
- R8: With `duty_full`=0 and `com_release`=1, `com_oe[7:4]` is 0. With `duty_full`=1, `com_release` has no effect and `com_oe` stays all ones. `com_oe[3:0]` is always 1.
- R9: `seg_release[g]`=1 clears `seg_oe` for segments 16+4g to 19+4g. `seg_oe[15:0]` is always 1.
- R10: Reset clears all display words and sets the scan to common 0, positive polarity, at the start of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_full | input | 1 | 1: eight commons scanned, 0: four commons |
| bias_quarter | input | 1 | 1: five levels (T=4), 0: four levels (T=3) |
| rate_code | input | 4 | Frame-rate setting |
| com_release | input | 1 | Hand commons 4..7 to general I/O (four-common mode) |
| seg_release | input | 6 | Hand a block of four segments (16..39) to general I/O |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 7 | Display word address |
| wr_data | input | 4 | Display word data |
| com_lvl | output | 24 | Level code per common, 3 bits each, common 0 in the low bits |
| seg_lvl | output | 120 | Level code per segment, 3 bits each, segment 0 in the low bits |
| com_oe | output | 8 | Output enable per common pin |
| seg_oe | output | 40 | Output enable per segment pin |

## Verification
The hardest case to reach from the ports is the negative-polarity frame combined with the upper display words. It needs a full scan to have elapsed and the commons 4 to 7 half of the eight-common mode to be active while pixel data sits in the odd words. The bench therefore fills the memory with address-dependent patterns and sweeps at least two full frames in every duty and bias combination, comparing all 48 pin codes on every cycle. Each configuration starts from a reset, so the bench can work out the phase, the active common and the polarity purely from the elapsed clock count.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;
   localparam int LVL_W = 3;
   typedef logic [LVL_W-1:0] lvl_t;

   // level code for one pin: positive polarity values, mirrored about the top level
   function automatic lvl_t lvl_pick(input logic is_com, input logic active,
                                     input logic inv, input logic five_lvl);
      lvl_t top;
      lvl_t base;
      top = five_lvl ? lvl_t'(4) : lvl_t'(3);
      if (is_com) base = active ? top : lvl_t'(1);
      else        base = active ? lvl_t'(0) : lvl_t'(2);
      return inv ? lvl_t'(top - base) : base;
   endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
`timescale 1ns/1ps
module lcd_frame_timer #(
   parameter int UNIT    = 8,
   parameter int RATE_W  = 4,
   parameter int NUM_COM = 8,
   localparam int CW     = $clog2(NUM_COM),
   localparam int CNT_W  = RATE_W + $clog2(UNIT) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              duty_full,
   input  logic [RATE_W-1:0] rate,
   output logic [CW-1:0]     com_idx,
   output logic              inv
);
   localparam int HALF = NUM_COM / 2;

   logic [CNT_W-1:0] tick;
   logic [CNT_W-1:0] phase_len;
   logic [CW-1:0]    last_com;
   logic             phase_end;

   always_comb begin
      phase_len = (CNT_W'(rate) + CNT_W'(1)) * CNT_W'(UNIT);
      if (!duty_full) phase_len = phase_len << 1;
      last_com  = duty_full ? CW'(NUM_COM - 1) : CW'(HALF - 1);
      phase_end = (tick >= phase_len - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick    <= '0;
         com_idx <= '0;
         inv     <= 1'b0;
      end else if (phase_end) begin
         tick <= '0;
         if (com_idx >= last_com) begin
            com_idx <= '0;
            inv     <= ~inv;
         end else begin
            com_idx <= com_idx + CW'(1);
         end
      end else begin
         tick <= tick + CNT_W'(1);
      end
   end

   // R3
   com_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!duty_full && com_idx >= CW'(HALF - 1) && phase_end) |=> com_idx == '0);

   // R5
   pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv != $past(inv)) |-> com_idx == '0);
endmodule

// File: rtl/lcd_disp_ram.sv
`timescale 1ns/1ps
module lcd_disp_ram #(
   parameter int WORDS = 80,
   parameter int DW    = 4,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [DW-1:0]       wdata,
   output logic [WORDS*DW-1:0] flat
);
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (we && (32'(waddr) < WORDS)) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_out
      assign flat[w*DW +: DW] = mem[w];
   end

   // R7
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (32'(waddr) < WORDS)) |=> flat[$past(waddr)*DW +: DW] == $past(wdata));
endmodule

// File: rtl/lcd_level_map.sv
`timescale 1ns/1ps
module lcd_level_map
   import lcd_seq_pkg::*;
#(
   parameter int NUM_SEG = 40,
   parameter int NUM_COM = 8,
   parameter int DW      = 4,
   localparam int WORDS  = NUM_SEG * 2,
   localparam int CW     = $clog2(NUM_COM),
   localparam int BW     = $clog2(DW)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORDS*DW-1:0]      ram_flat,
   input  logic [CW-1:0]            com_idx,
   input  logic                     inv,
   input  logic                     duty_full,
   input  logic                     five_lvl,
   output logic [NUM_COM*LVL_W-1:0] com_lvl,
   output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);
   localparam int HALF = NUM_COM / 2;

   logic          upper;
   logic [BW-1:0] bit_sel;
   lvl_t          top;

   assign upper   = (com_idx >= CW'(HALF));
   assign bit_sel = com_idx[BW-1:0];
   assign top     = five_lvl ? lvl_t'(4) : lvl_t'(3);

   for (genvar c = 0; c < NUM_COM; c++) begin : g_com
      logic act;
      if (c < HALF) begin : g_low
         assign act = (com_idx == CW'(c));
      end else begin : g_high
         assign act = duty_full && (com_idx == CW'(c));
      end
      assign com_lvl[c*LVL_W +: LVL_W] = lvl_pick(1'b1, act, inv, five_lvl);

      // R4
      com_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         com_lvl[c*LVL_W +: LVL_W] <= top);
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic [DW-1:0] word;
      logic          lit;
      assign word = upper ? ram_flat[(2*s+1)*DW +: DW] : ram_flat[(2*s)*DW +: DW];
      assign lit  = word[bit_sel];
      assign seg_lvl[s*LVL_W +: LVL_W] = lvl_pick(1'b0, lit, inv, five_lvl);

      // R4
      seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         seg_lvl[s*LVL_W +: LVL_W] <= top);
   end
endmodule

// File: rtl/lcd_scan_seq.sv
`timescale 1ns/1ps
module lcd_scan_seq
   import lcd_seq_pkg::*;
#(
   parameter int NUM_SEG     = 40,
   parameter int NUM_COM     = 8,
   parameter int DW          = 4,
   parameter int RATE_W      = 4,
   parameter int UNIT        = 8,
   parameter int SHARE_FIRST = 16,
   parameter int GROUP_W     = 4,
   localparam int N_GROUPS   = (NUM_SEG - SHARE_FIRST) / GROUP_W,
   localparam int WORDS      = NUM_SEG * 2,
   localparam int AW         = $clog2(WORDS),
   localparam int CW         = $clog2(NUM_COM)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     duty_full,
   input  logic                     bias_quarter,
   input  logic [RATE_W-1:0]        rate_code,
   input  logic                     com_release,
   input  logic [N_GROUPS-1:0]      seg_release,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DW-1:0]            wr_data,
   output logic [NUM_COM*LVL_W-1:0] com_lvl,
   output logic [NUM_SEG*LVL_W-1:0] seg_lvl,
   output logic [NUM_COM-1:0]       com_oe,
   output logic [NUM_SEG-1:0]       seg_oe
);
   localparam int HALF = NUM_COM / 2;

   if (HALF != DW) begin : g_bad_half
      $error("half the commons must equal the display word width");
   end
   if ((NUM_SEG - SHARE_FIRST) % GROUP_W != 0 || SHARE_FIRST > NUM_SEG) begin : g_bad_grp
      $error("shared segment range must split into whole groups");
   end

   logic [CW-1:0]         com_idx;
   logic                  inv;
   logic [WORDS*DW-1:0]   ram_flat;

   lcd_frame_timer #(.UNIT(UNIT), .RATE_W(RATE_W), .NUM_COM(NUM_COM)) u_timer (
      .clk(clk), .rst_n(rst_n), .duty_full(duty_full), .rate(rate_code),
      .com_idx(com_idx), .inv(inv));

   lcd_disp_ram #(.WORDS(WORDS), .DW(DW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .flat(ram_flat));

   lcd_level_map #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .DW(DW)) u_map (
      .clk(clk), .rst_n(rst_n), .ram_flat(ram_flat), .com_idx(com_idx), .inv(inv),
      .duty_full(duty_full), .five_lvl(bias_quarter),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl));

   for (genvar c = 0; c < NUM_COM; c++) begin : g_coe
      if (c < HALF) begin : g_fixed
         assign com_oe[c] = 1'b1;
      end else begin : g_shared
         assign com_oe[c] = duty_full | ~com_release;
      end
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_soe
      if (s < SHARE_FIRST) begin : g_fixed
         assign seg_oe[s] = 1'b1;
      end else begin : g_shared
         assign seg_oe[s] = ~seg_release[(s - SHARE_FIRST) / GROUP_W];
      end
   end

   // checker-side count of commons sitting at an extreme level
   logic [CW:0] sel_cnt;
   lvl_t        top_chk;
   always_comb begin
      top_chk = bias_quarter ? lvl_t'(4) : lvl_t'(3);
      sel_cnt = '0;
      for (int c = 0; c < NUM_COM; c++) begin
         if (com_lvl[c*LVL_W +: LVL_W] == '0 || com_lvl[c*LVL_W +: LVL_W] == top_chk)
            sel_cnt = sel_cnt + (CW+1)'(1);
      end
   end

   // R2
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      duty_full |-> sel_cnt == (CW+1)'(1));
endmodule

// File: tb/tb_lcd_scan_seq.sv
`timescale 1ns/1ps
module tb_lcd_scan_seq;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         duty_full = 1'b1;
   logic         bias_quarter = 1'b0;
   logic [3:0]   rate_code = 4'd7;
   logic         com_release = 1'b0;
   logic [5:0]   seg_release = '0;
   logic         wr_en = 1'b0;
   logic [6:0]   wr_addr = '0;
   logic [3:0]   wr_data = '0;
   logic [23:0]  com_lvl;
   logic [119:0] seg_lvl;
   logic [7:0]   com_oe;
   logic [39:0]  seg_oe;

   int checks = 0;
   int errs = 0;
   int n = 0;
   bit done = 0;
   logic [3:0] mem [80];

   lcd_scan_seq dut (
      .clk(clk), .rst_n(rst_n), .duty_full(duty_full), .bias_quarter(bias_quarter),
      .rate_code(rate_code), .com_release(com_release), .seg_release(seg_release),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl), .com_oe(com_oe), .seg_oe(seg_oe));

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) n <= 0;
      else        n <= n + 1;
   end

   task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic restart(bit df, bit bq, logic [3:0] rc);
      @(negedge clk);
      rst_n = 1'b0;
      duty_full = df; bias_quarter = bq; rate_code = rc;
      for (int i = 0; i < 80; i++) mem[i] = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(int a, logic [3:0] d);
      wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
      @(posedge clk);
      if (a < 80) mem[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fill(int mul, int add);
      for (int a = 0; a < 80; a++) wr(a, 4'((a * mul + add) % 16));
   endtask

   // expected codes from the elapsed clock count
   task automatic check_all(string req);
      int ncom, plen, k, t, inv, base;
      logic [23:0]  ec;
      logic [119:0] es;
      ncom = duty_full ? 8 : 4;
      plen = (int'(rate_code) + 1) * 8 * (duty_full ? 1 : 2);
      k    = (n / plen) % ncom;
      inv  = (n / (plen * ncom)) % 2;
      t    = bias_quarter ? 4 : 3;
      for (int c = 0; c < 8; c++) begin
         base = (c == k) ? t : 1;
         ec[c*3 +: 3] = 3'(inv ? t - base : base);
      end
      for (int s = 0; s < 40; s++) begin
         logic [3:0] w;
         w = mem[2*s + ((k >= 4) ? 1 : 0)];
         base = w[k % 4] ? 0 : 2;
         es[s*3 +: 3] = 3'(inv ? t - base : base);
      end
      chk(req, "com_lvl", 128'(com_lvl), 128'(ec));
      chk(req, "seg_lvl", 128'(seg_lvl), 128'(es));
   endtask

   task automatic sweep(string req, int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check_all(req);
      end
   endtask

   initial begin
      // R10: reset state, cleared memory
      @(negedge clk);
      check_all("R10");
      restart(1'b1, 1'b0, 4'd0);
      @(negedge clk);
      check_all("R10");

      // R1 R2 R4 R5 R6: eight commons, four levels, frame of 64
      fill(5, 3);
      sweep("R1 R2 R4 R5 R6", 140);

      // R7: single write visible the next cycle
      wr(71, 4'hF);
      check_all("R7");
      wr(6, 4'h0);
      check_all("R7");
      wr(100, 4'h9);   // out of range, no effect
      check_all("R7");

      // R4 R5 R6: eight commons, five levels, slower rate
      restart(1'b1, 1'b1, 4'd2);
      fill(7, 1);
      sweep("R1 R4 R5 R6", 420);

      // R3: four commons, both biases
      restart(1'b0, 1'b0, 4'd1);
      fill(3, 10);
      sweep("R1 R3 R5 R6", 280);
      restart(1'b0, 1'b1, 4'd0);
      fill(11, 4);
      sweep("R3 R4 R5", 150);

      // R1: reset rate code, frame of 512 clocks
      restart(1'b1, 1'b0, 4'd7);
      fill(13, 2);
      sweep("R1 R5", 1100);

      // R8: common release in both duty modes
      for (int df = 0; df < 2; df++) begin
         for (int cr = 0; cr < 2; cr++) begin
            @(negedge clk);
            duty_full = 1'(df); com_release = 1'(cr);
            #1;
            chk("R8", "com_oe", 128'(com_oe),
                128'((df == 0 && cr == 1) ? 8'h0F : 8'hFF));
         end
      end
      com_release = 1'b0;

      // R9: every segment release combination
      for (int g = 0; g < 64; g++) begin
         logic [39:0] eo;
         @(negedge clk);
         seg_release = 6'(g);
         #1;
         for (int s = 0; s < 40; s++)
            eo[s] = (s < 16) ? 1'b1 : !seg_release[(s - 16) / 4];
         chk("R9", "seg_oe", 128'(seg_oe), 128'(eo));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(64'd8 * 64'd200000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule